// File: doc/BRIEF.md
# Capture Timer With Overflow Status

A single timer channel with a 16-bit up-counter. The counter advances on a count-enable tick. On a rising edge of the capture input it copies its current value into a capture register. A 16-bit read-only status word reports, in bit 0, whether the counter wrapped during the interval that was just captured. The flag is sticky between captures. It changes only when a capture happens, so software that reads the capture register together with the flag can tell whether the measured interval is longer than the counter range.

A 3-bit mode field selects the operation. In free capture mode (3'b010) the counter runs whenever ticks arrive, and it restarts from zero at each capture. In one-count mode (3'b110) the counter sits idle until a start trigger arrives. It then counts until the next capture edge, stores its value, stops, and waits for another start. Any other mode value parks the channel: the counter is stopped and cleared, the overflow state is discarded, and the capture register keeps its last value.

Top module: `ovf_capture_timer`

## Requirements
- R1: The mode encodings are 3'b010 (free capture) and 3'b110 (one-count capture). With any other mode value, the counter is held at zero and capture_o keeps its value whatever tick_i, cap_i and start_i do.
- R2: In free capture mode, the cycle after a capture edge capture_o holds the number of counted ticks since the previous capture, modulo 2^16. The tick in the capture cycle is not counted, and the next interval counts from zero.
- R3: status_o[15:1] always reads zero.
- R4: A counter wrap from 16'hFFFF to 16'h0000 leaves status_o[0] unchanged. The flag changes only at a capture, at reset, or on leaving the capture modes.
- R5: At a capture, status_o[0] becomes 1 if the counter wrapped since the previous capture.
- R6: At a capture, status_o[0] becomes 0 if the counter did not wrap since the previous capture.
- R7: A wrap in the same cycle as a capture edge belongs to the following interval. That capture stores 16'hFFFF and reports no wrap, and the next capture reports a wrap.
- R8: After reset, capture_o and status_o are 16'h0000.
- R9: In one-count mode, counting begins from zero on start_i. A capture edge stores the count and stops the counter. Capture edges while the counter is stopped leave capture_o and status_o unchanged.
- R10: In a mode other than the two capture modes, status_o[0] reads 0 and any pending wrap is discarded.
- R11: A capture happens only on a 0-to-1 transition of cap_i. Holding cap_i high produces a single capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one increment per high cycle |
| cap_i | input | 1 | Capture input, acts on rising edge |
| mode_i | input | 3 | Operating mode select |
| start_i | input | 1 | Start trigger for one-count mode |
| capture_o | output | 16 | Captured counter value |
| status_o | output | 16 | Status word, bit 0 is the overflow flag |

## Verification
Any internal fault reaches the ports only at a capture. A wrong pending-wrap bit stays hidden until the next capture edge, where it shows up as a flipped status_o[0]. A wrong count shows up as a wrong capture_o value one cycle after that edge. For this reason the stimulus places captures right after wraps, in the same cycle as a wrap, and after mode changes, so that each kind of corrupted state is forced to the outputs within a cycle of being created. A model in the bench is compared against both outputs on every cycle, and each failed comparison prints a line with the word FAIL and the requirement it belongs to.

// File: rtl/ovfcap_pkg.sv
package ovfcap_pkg;

  localparam logic [2:0] MODE_FREE_CAPT = 3'b010;
  localparam logic [2:0] MODE_ONE_CAPT  = 3'b110;

  typedef struct packed {
    logic free_run;
    logic one_shot;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [2:0] m);
    mode_dec_t d;
    d.free_run = (m == MODE_FREE_CAPT);
    d.one_shot = (m == MODE_ONE_CAPT);
    return d;
  endfunction

endpackage

// File: rtl/ovfcap_edge.sv
module ovfcap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);

  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;

  // R11: no two consecutive rising events
  assert_single_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/ovfcap_counter.sv
module ovfcap_counter
  import ovfcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cap_evt_i,
  input  logic             start_i,
  input  mode_dec_t        mode_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             wrap_o,
  output logic             cap_valid_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cap_q;
  logic             run_q;
  logic             active;

  assign active      = mode_i.free_run | (mode_i.one_shot & run_q);
  assign wrap_o      = active & tick_i & (cnt_q == CNT_MAX);
  assign cap_valid_o = active & cap_evt_i;
  assign cap_val_o   = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cap_q <= '0;
      run_q <= 1'b0;
    end else if (!(mode_i.free_run | mode_i.one_shot)) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cap_valid_o) begin
      cap_q <= cnt_q;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (active && tick_i) cnt_q <= cnt_q + 1'b1;
      if (mode_i.free_run) begin
        run_q <= 1'b0;
      end else if (!run_q && start_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end
    end
  end

  assert_restart_after_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid_o |=> (cnt_q == '0));

  assert_idle_holds_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.one_shot && !run_q) |=> $stable(cap_q));

  assert_parked_counter_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_i.free_run | mode_i.one_shot) |=> ((cnt_q == '0) && $stable(cap_q)));

endmodule

// File: rtl/ovfcap_status.sv
module ovfcap_status #(
  parameter int STAT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_mode_i,
  input  logic              cap_valid_i,
  input  logic              wrap_i,
  output logic [STAT_W-1:0] status_o
);

  logic pend_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (!cap_mode_i) begin
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (cap_valid_i) begin
      flag_q <= pend_q;
      pend_q <= wrap_i;   // coincident wrap goes to next interval
    end else begin
      pend_q <= pend_q | wrap_i;
    end
  end

  assign status_o = {{(STAT_W-1){1'b0}}, flag_q};

  assert_flag_only_on_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode_i && !cap_valid_i) |=> $stable(flag_q));

  assert_flag_takes_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid_i |=> (flag_q == $past(pend_q)));

  assert_coincident_wrap_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode_i && wrap_i) |=> pend_q);

  assert_parked_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_mode_i |=> (!flag_q && !pend_q));

endmodule

// File: rtl/ovf_capture_timer.sv
module ovf_capture_timer
  import ovfcap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STAT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cap_i,
  input  logic [2:0]        mode_i,
  input  logic              start_i,
  output logic [CNT_W-1:0]  capture_o,
  output logic [STAT_W-1:0] status_o
);

  mode_dec_t mode_dec;
  logic      cap_evt, wrap, cap_valid;

  assign mode_dec = decode_mode(mode_i);

  ovfcap_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (cap_i),
    .rise_o (cap_evt)
  );

  ovfcap_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .cap_evt_i   (cap_evt),
    .start_i     (start_i),
    .mode_i      (mode_dec),
    .cap_val_o   (capture_o),
    .wrap_o      (wrap),
    .cap_valid_o (cap_valid)
  );

  ovfcap_status #(.STAT_W(STAT_W)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_mode_i  (mode_dec.free_run | mode_dec.one_shot),
    .cap_valid_i (cap_valid),
    .wrap_i      (wrap),
    .status_o    (status_o)
  );

  assert_status_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[STAT_W-1:1] == '0);

endmodule

// File: tb/ovf_capture_timer_bench.sv
module ovf_capture_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_r = 1'b0, cap_r = 1'b0, start_r = 1'b0;
  logic [2:0]  mode_r = 3'b000;
  logic [15:0] capture_w, status_w;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_cnt = '0, m_cap = '0;
  logic        m_run = 0, m_capd = 0, m_pend = 0, m_flag = 0;

  always #4 clk = ~clk;

  ovf_capture_timer u_ovf_capture_timer (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick_r), .cap_i (cap_r),
    .mode_i (mode_r), .start_i (start_r),
    .capture_o (capture_w), .status_o (status_w)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status();
    return {15'b0, m_flag};
  endfunction

  task automatic model_step();
    logic evt, cm, om, act, wrap, valid;
    evt = cap_r & ~m_capd;
    m_capd = cap_r;
    cm = (mode_r == 3'b010);
    om = (mode_r == 3'b110);
    if (!cm && !om) begin
      m_cnt = 0; m_run = 0; m_pend = 0; m_flag = 0;
    end else begin
      act   = cm | m_run;
      wrap  = act & tick_r & (m_cnt == 16'hFFFF);
      valid = act & evt;
      if (valid) begin
        m_cap = m_cnt; m_flag = m_pend; m_pend = wrap; m_cnt = 0; m_run = 0;
      end else begin
        m_pend = m_pend | wrap;
        if (act && tick_r) m_cnt = m_cnt + 16'd1;
        if (cm) m_run = 0;
        else if (!m_run && start_r) begin m_run = 1; m_cnt = 0; end
      end
    end
  endtask

  task automatic step(input logic t, input logic c, input logic [2:0] m, input logic s);
    tick_r = t; cap_r = c; mode_r = m; start_r = s;
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic step_chk(input logic t, input logic c, input logic [2:0] m, input logic s,
                          input string tag);
    step(t, c, m, s);
    chk(capture_w, m_cap, tag);
    chk(status_w, exp_status(), tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(capture_w, 16'h0000, "R8 capture");
    chk(status_w, 16'h0000, "R8 status");
    rst_n = 1'b1;
    @(negedge clk);

    // R2: ten ticks then capture
    for (int i = 0; i < 10; i++) step_chk(1, 0, 3'b010, 0, "R2");
    step(1, 1, 3'b010, 0);
    chk(capture_w, 16'd10, "R2 count");
    // R11: held high, no second capture
    for (int i = 0; i < 4; i++) step_chk(1, 1, 3'b010, 0, "R11");
    chk(capture_w, 16'd10, "R11 hold");
    step_chk(1, 0, 3'b010, 0, "R2");
    step(0, 1, 3'b010, 0);
    chk(capture_w, 16'd5, "R2 restart");

    // R4/R5: wrap, flag silent until capture
    step_chk(1, 0, 3'b010, 0, "R4");
    for (int i = 0; i < 65540; i++) step_chk(1, 0, 3'b010, 0, "R4");
    chk(status_w, 16'h0000, "R4 no change at wrap");
    step(0, 1, 3'b010, 0);
    chk(status_w, 16'h0001, "R5 flag set");
    step_chk(1, 0, 3'b010, 0, "R6");
    step_chk(1, 0, 3'b010, 0, "R6");
    step(0, 1, 3'b010, 0);
    chk(status_w, 16'h0000, "R6 flag cleared");
    chk(capture_w, 16'd2, "R6 count");

    // R7: wrap coincident with capture
    for (int i = 0; i < 65535; i++) step(1, 0, 3'b010, 0);
    step(1, 1, 3'b010, 0);
    chk(capture_w, 16'hFFFF, "R7 capture value");
    chk(status_w, 16'h0000, "R7 flag this interval");
    step_chk(1, 0, 3'b010, 0, "R7");
    step(0, 1, 3'b010, 0);
    chk(status_w, 16'h0001, "R7 flag next interval");

    // R10/R1: parked mode
    held = capture_w;
    step(1, 0, 3'b000, 1);
    chk(status_w, 16'h0000, "R10 flag cleared");
    for (int i = 0; i < 6; i++) step_chk(1, i[0], 3'b101, 1, "R1");
    chk(capture_w, held, "R1 capture held");
    step(1, 0, 3'b010, 0);
    step(0, 1, 3'b010, 0);
    chk(capture_w, 16'd1, "R1 counter was cleared");
    chk(status_w, 16'h0000, "R10 pending discarded");

    // R9: one-count mode
    step(1, 0, 3'b110, 0);
    step(1, 1, 3'b110, 0);
    chk(capture_w, 16'd1, "R9 idle capture ignored");
    step(1, 0, 3'b110, 1);
    for (int i = 0; i < 7; i++) step(1, 0, 3'b110, 0);
    step(1, 1, 3'b110, 0);
    chk(capture_w, 16'd7, "R9 counted from start");
    step(1, 0, 3'b110, 0);
    step(1, 1, 3'b110, 0);
    chk(capture_w, 16'd7, "R9 stopped");

    // random mix, R3 on every cycle
    for (int i = 0; i < 6000; i++) begin
      logic [2:0] m;
      int r = $urandom_range(0, 9);
      m = (r < 5) ? 3'b010 : (r < 9) ? 3'b110 : 3'($urandom_range(0, 7));
      step_chk(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 7) == 0), m,
               1'($urandom_range(0, 5) == 0), "R2 random");
      chk({status_w[15:1], 1'b0}, 16'h0000, "R3");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule